// File: doc/BRIEF.md
# USB Host Start-of-Frame Scheduler

This block paces a full-speed USB host in 1 ms frames. Software loads a starting frame number, then issues a start command. The block raises a start-of-frame request toward the packet engine at once, and again every frame after that. A down-counter driven by a 12 MHz bit-time enable sets the frame length. An 11-bit frame number travels with each request and advances by one each time the packet engine accepts a request. Clearing the busy flag halts the timer and withdraws any request that has not yet been taken.

Two services are built around the frame timer. The first is an interrupt flag. It is set when a request starts and the low byte of the frame number equals a programmable compare byte. In step mode it is set at every frame start instead. The second is a guard on ordinary IN, OUT and SETUP token requests: near the end of a frame, and while a start-of-frame request is still pending, new tokens are held back. A transaction therefore never runs into the next frame marker.

Top module: `sof_frame_scheduler`

## Requirements
- R1: After reset, every register reads 0, busy is 0, `sofValid` is 0 and `irq` is 0.
- R2: A write to address 7 with bit 0 set, while busy is 0, sets busy and raises `sofValid` on the next cycle. The same write while busy is 1 has no effect.
- R3: While busy, the frame counter advances only on cycles with `bitTick` high. Successive requests start exactly `FRAME_TICKS` ticks apart.
- R4: While `sofReady` is low, `sofValid` and `sofFrameNum` hold. Each accepted request adds one to the frame number, and 2047 wraps to 0.
- R5: The timer keeps counting while a request is stalled. A frame boundary reached while a request is pending adds no second request.
- R6: Writing address 1 with bit 0 clear stops the timer, clears busy and drops a pending request. Writing 1 to that bit never sets busy.
- R7: With step mode off, the interrupt flag (address 1 bit 1, driven on `irq`) is set in the cycle `sofValid` rises, if and only if the frame number's low byte equals the compare byte at address 2.
- R8: With step mode on (address 0 bit 0), the interrupt flag is set at every request start, whatever the compare byte.
- R9: Writing address 1 with bit 1 clear clears the interrupt flag. Writing 1 to bit 1 leaves it unchanged.
- R10: `tokGrant` equals `tokReq` while busy is 0. While busy, `tokGrant` is 0 whenever a request is pending or the counter is below the guard limit at addresses 3 (low byte) and 4 (high byte).
- R11: The register map reads back as written. Address 0 bit 0 is step mode, 2 is the compare byte, 3/4 the guard limit, 5 the frame low byte, 6 bits 2:0 the frame high bits, and 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | 12 MHz bit-time enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| sofValid | output | 1 | Start-of-frame request to packet engine |
| sofReady | input | 1 | Packet engine accepts the request |
| sofFrameNum | output | 11 | Frame number carried by the request |
| tokReq | input | 1 | Pending IN/OUT/SETUP token request |
| tokGrant | output | 1 | Token may be sent now |
| irq | output | 1 | Frame interrupt flag |

## Verification
A counter that is off by one shows as a request period different from `FRAME_TICKS`, and as a guard window that opens or closes one cycle early or late. Both are visible within a single frame. A wrong frame register surfaces on `sofFrameNum` at the next request, and through the interrupt, which then fires on the wrong frame. A busy or pending flag that gets out of step shows as a lost, doubled or orphan request, or as a token granted while a request waits. Every one of these faults appears within one frame of the event that caused it.

// File: rtl/sofs_pkg.sv
package sofs_pkg;
  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_STAT  = 3'd1;
  localparam logic [2:0] ADDR_CMP   = 3'd2;
  localparam logic [2:0] ADDR_GRDLO = 3'd3;
  localparam logic [2:0] ADDR_GRDHI = 3'd4;
  localparam logic [2:0] ADDR_FRMLO = 3'd5;
  localparam logic [2:0] ADDR_FRMHI = 3'd6;
  localparam logic [2:0] ADDR_CMD   = 3'd7;

  localparam int FRAME_W = 11;

  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic incFrame;
  } strobe_t;
endpackage

// File: rtl/sofs_ctrl.sv
module sofs_ctrl
  import sofs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       countZero,
  input  logic       cmpMatch,
  input  logic       sofReady,
  output strobe_t    strb,
  output logic       busy,
  output logic       sofValid,
  output logic       irqFlag,
  output logic       stepMode
);
  logic cmdStart, statWr, stopReq, tickWrap, sofStart, accept, setIrq;

  always_comb begin
    cmdStart = regWrEn && (regAddr == ADDR_CMD) && regWrData[0] && !busy;
    statWr   = regWrEn && (regAddr == ADDR_STAT);
    stopReq  = statWr && !regWrData[0] && busy;
    tickWrap = busy && bitTick && countZero;
    sofStart = cmdStart || (tickWrap && !stopReq);
    accept   = sofValid && sofReady;
    setIrq   = sofStart && (stepMode || cmpMatch);
    strb.loadCount = sofStart;
    strb.decCount  = busy && bitTick && !countZero && !stopReq;
    strb.incFrame  = accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      sofValid <= 1'b0;
      irqFlag  <= 1'b0;
      stepMode <= 1'b0;
    end else begin
      if (cmdStart)     busy <= 1'b1;
      else if (stopReq) busy <= 1'b0;

      if (stopReq)       sofValid <= 1'b0;
      else if (sofStart) sofValid <= 1'b1;
      else if (accept)   sofValid <= 1'b0;

      if (setIrq)                      irqFlag <= 1'b1;
      else if (statWr && !regWrData[1]) irqFlag <= 1'b0;

      if (regWrEn && regAddr == ADDR_CTRL) stepMode <= regWrData[0];
    end
  end
endmodule

// File: rtl/sofs_dpath.sv
module sofs_dpath
  import sofs_pkg::*;
#(
  parameter int FRAME_TICKS = 12000,
  localparam int COUNT_W = $clog2(FRAME_TICKS)
)(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [7:0]         regWrData,
  input  logic               busy,
  input  logic               irqFlag,
  input  logic               stepMode,
  output logic               countZero,
  output logic               cmpMatch,
  output logic               inGuard,
  output logic [FRAME_W-1:0] frameNum,
  output logic [7:0]         regRdData
);
  localparam logic [COUNT_W-1:0] RELOAD = COUNT_W'(FRAME_TICKS - 1);

  logic [COUNT_W-1:0] count;
  logic [7:0]         cmpReg;
  logic [15:0]        guardReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      frameNum <= '0;
      cmpReg   <= '0;
      guardReg <= '0;
    end else begin
      if (strb.loadCount)     count <= RELOAD;
      else if (strb.decCount) count <= count - 1'b1;

      if (regWrEn && regAddr == ADDR_FRMLO)      frameNum[7:0] <= regWrData;
      else if (regWrEn && regAddr == ADDR_FRMHI) frameNum[FRAME_W-1:8] <= regWrData[FRAME_W-9:0];
      else if (strb.incFrame)                    frameNum <= frameNum + 1'b1;

      if (regWrEn && regAddr == ADDR_CMP)   cmpReg <= regWrData;
      if (regWrEn && regAddr == ADDR_GRDLO) guardReg[7:0] <= regWrData;
      if (regWrEn && regAddr == ADDR_GRDHI) guardReg[15:8] <= regWrData;
    end
  end

  always_comb begin
    countZero = (count == '0);
    cmpMatch  = (frameNum[7:0] == cmpReg);
    inGuard   = (16'(count) < guardReg);
    unique case (regAddr)
      ADDR_CTRL:  regRdData = {7'd0, stepMode};
      ADDR_STAT:  regRdData = {6'd0, irqFlag, busy};
      ADDR_CMP:   regRdData = cmpReg;
      ADDR_GRDLO: regRdData = guardReg[7:0];
      ADDR_GRDHI: regRdData = guardReg[15:8];
      ADDR_FRMLO: regRdData = frameNum[7:0];
      ADDR_FRMHI: regRdData = 8'(frameNum[FRAME_W-1:8]);
      default:    regRdData = 8'd0;
    endcase
  end
endmodule

// File: rtl/sof_frame_scheduler.sv
module sof_frame_scheduler
  import sofs_pkg::*;
#(
  parameter int FRAME_TICKS = 12000
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic               sofValid,
  input  logic               sofReady,
  output logic [FRAME_W-1:0] sofFrameNum,
  input  logic               tokReq,
  output logic               tokGrant,
  output logic               irq
);
  strobe_t strb;
  logic busyFlag, irqFlag, stepMode, countZero, cmpMatch, inGuard;

  sofs_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .countZero(countZero), .cmpMatch(cmpMatch), .sofReady(sofReady),
    .strb(strb), .busy(busyFlag), .sofValid(sofValid),
    .irqFlag(irqFlag), .stepMode(stepMode)
  );

  sofs_dpath #(.FRAME_TICKS(FRAME_TICKS)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .busy(busyFlag), .irqFlag(irqFlag), .stepMode(stepMode),
    .countZero(countZero), .cmpMatch(cmpMatch), .inGuard(inGuard),
    .frameNum(sofFrameNum), .regRdData(regRdData)
  );

  assign tokGrant = tokReq && !(busyFlag && (sofValid || inGuard));
  assign irq      = irqFlag;
endmodule

// File: rtl/sofs_checker.sv
module sofs_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic        sofValid,
  input logic        sofReady,
  input logic [10:0] sofFrameNum,
  input logic        tokReq,
  input logic        tokGrant,
  input logic        irq,
  input logic        busy
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    sofValid && !sofReady && !regWrEn |=> sofValid && $stable(sofFrameNum));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    sofValid && sofReady && !regWrEn |=> sofFrameNum == 11'($past(sofFrameNum) + 11'd1));

  p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    tokGrant |-> tokReq);

  p_no_grant_pending_r10: assert property (@(posedge clk) disable iff (!rstN)
    sofValid |-> !tokGrant);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWrEn && regAddr == 3'd1) |=> irq);

  p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sofValid);
endmodule

bind sof_frame_scheduler sofs_checker i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .sofValid(sofValid), .sofReady(sofReady), .sofFrameNum(sofFrameNum),
  .tokReq(tokReq), .tokGrant(tokGrant), .irq(irq), .busy(busyFlag)
);

// File: tb/test_sof_frame_scheduler.sv
module test_sof_frame_scheduler;
  localparam int FT = 20;
  localparam int NVEC = 8;
  localparam logic [23:0] VECS [NVEC] = '{
    {8'd2, 8'h5A, 8'h5A}, {8'd3, 8'h34, 8'h34}, {8'd4, 8'h12, 8'h12},
    {8'd5, 8'hC3, 8'hC3}, {8'd6, 8'hFF, 8'h07}, {8'd0, 8'hFF, 8'h01},
    {8'd1, 8'h03, 8'h00}, {8'd7, 8'h00, 8'h00}
  };

  logic clk = 0, rstN = 0, bitTick = 1, regWrEn = 0, sofReady = 0, tokReq = 0;
  logic [2:0] regAddr = 0;
  logic [7:0] regWrData = 0, regRdData;
  logic sofValid, tokGrant, irq;
  logic [10:0] sofFrameNum;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sof_frame_scheduler #(.FRAME_TICKS(FT)) i_sof_frame_scheduler (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sofValid(sofValid), .sofReady(sofReady), .sofFrameNum(sofFrameNum),
    .tokReq(tokReq), .tokGrant(tokGrant), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(posedge clk); @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    regAddr = a; #1 d = regRdData;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic setFrame(logic [10:0] f);
    wr(3'd5, f[7:0]); wr(3'd6, {5'd0, f[10:8]});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reg reset", d, 0);
    end
    check("R1 sofValid", sofValid, 0);
    check("R1 irq", irq, 0);
    tokReq = 1; #1 check("R10 idle grant", tokGrant, 1);

    // R11/R6/R9 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][18:16], VECS[i][15:8]);
      rd(VECS[i][18:16], d);
      check("R11 readback (R6/R9 for addr 1)", d, VECS[i][7:0]);
    end
    wr(3'd0, 8'h00);

    // R2 R3 R7 R10 R4: frame 5, compare 6, guard 5
    wr(3'd3, 8'd5); wr(3'd4, 8'd0); wr(3'd2, 8'd6); setFrame(11'd5);
    sofReady = 1;
    wr(3'd7, 8'h01);
    check("R2 start valid", sofValid, 1);
    check("R4 frame at start", sofFrameNum, 5);
    check("R7 no match irq", irq, 0);
    check("R10 pending blocks", tokGrant, 0);
    for (int k = 1; k <= 21; k++) begin
      cyc();
      check("R3 period valid", sofValid, (k == 20));
      check("R10 guard window", tokGrant, !(k >= 15 && k <= 20));
      if (k == 20) begin
        check("R7 match irq", irq, 1);
        check("R4 frame incr", sofFrameNum, 6);
      end
    end
    // R2 start while busy ignored
    wr(3'd7, 8'h01);
    check("R2 start while busy", sofValid, 0);
    // R9 clear irq, keep busy
    wr(3'd1, 8'h01);
    check("R9 clear", irq, 0);
    rd(3'd1, d); check("R9 busy kept", d, 8'h01);
    // R6 stop
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R6 stopped", d, 8'h00);
    begin
      int seen = 0;
      for (int k = 0; k < 3 * FT; k++) begin cyc(); seen += sofValid; end
      check("R6 no request after stop", seen, 0);
    end

    // R5 stall: timer keeps running
    sofReady = 0; setFrame(11'd100);
    wr(3'd7, 8'h01);
    for (int k = 1; k <= 40; k++) begin
      cyc();
      check("R5 stalled valid", sofValid, (k <= 25) || (k == 40));
      check("R5 frame", sofFrameNum, (k >= 26) ? 101 : 100);
      if (k == 25) sofReady = 1;
    end
    wr(3'd1, 8'h00);

    // R8 step mode
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); setFrame(11'd10);
    wr(3'd7, 8'h01);
    check("R8 step irq", irq, 1);
    wr(3'd1, 8'h01);
    for (int k = 0; k < FT; k++) cyc();
    check("R8 step irq next", irq, 1);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R4 wrap
    setFrame(11'd2047); wr(3'd2, 8'hAA);
    wr(3'd7, 8'h01);
    check("R4 wrap before", sofFrameNum, 2047);
    cyc();
    check("R4 wrap after", sofFrameNum, 0);
    rd(3'd6, d); check("R4 wrap high", d, 0);

    // R3 no tick, no count
    bitTick = 0;
    begin
      int seen = 0;
      for (int k = 0; k < 3 * FT; k++) begin cyc(); seen += sofValid; end
      check("R3 no tick no request", seen, 0);
    end
    bitTick = 1;
    wr(3'd1, 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule